// File: doc/BRIEF.md
# NAND Tree Connectivity Tester

This block checks the continuity of a group of digital input pads through a NAND tree. A chain of NAND stages combines the pads into a single observation output. With every pad high, that output is low. Each time one more pad is pulled low, following the pad index order, the output changes level. The tree becomes active when either a hardware strap input or a test-enable bit from a control register is set. While the tree is inactive, its output is held low.

A built-in walk sequencer exercises the tree on a start pulse. It first drives every pad high. It then pulls the pads low one at a time, from index 0 upward, and keeps each pad that has already been walked low. A pad that is open or shorted shows up because the registered tree output fails to toggle at that step. The sequencer records one fault flag per pad. It raises done when the walk ends, with pass asserted only when no pad is flagged, and it holds that result until done is acknowledged.

Top module: `nand_tree_checker`

## Requirements
- R1: During and after reset, done, pass and every pin_fault bit are 0, and pin_drive is all ones.
- R2: The tree is active when strap_en or cfg_test_en is 1. When both are 0, tree_out is 0 for every pad_in value.
- R3: When the tree is active, tree_out is 0 if every pad_in bit is 1. Otherwise it is 1 exactly when the highest-indexed pad_in bit that is 0 has an even index. As a result, lowering bits 0..k-1 gives tree_out equal to bit 0 of k.
- R4: The clock edge that accepts a start opens step 0, with pin_drive all ones. At step k, bits 0..k-1 of pin_drive are 0 and the rest are 1. Steps advance in ascending index order up to step NUM_PINS, where pin_drive is all zeros.
- R5: Each step lasts settle_cycles+2 clocks. done rises (NUM_PINS+1)*(settle_cycles+2) clock edges after the accepting edge.
- R6: pin_fault[i] is set when the tree_out level sampled at step i+1 equals the level sampled at step i. Otherwise it is clear. All bits are cleared when a new walk is accepted.
- R7: When done is 1, pass is 1 exactly when pin_fault is all zeros. pass is 0 whenever done is 0.
- R8: A start is ignored while done is 1, and also while the tree is inactive. In both cases done, pin_fault and pin_drive are left unchanged.
- R9: done_ack while done is 1 clears done on the next edge and returns pin_drive to all ones. pin_fault keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_en | input | 1 | Hardware strap that activates the tree |
| cfg_test_en | input | 1 | Register bit that activates the tree |
| settle_cycles | input | SETTLE_W | Extra settle clocks per walk step |
| start | input | 1 | Start a walk (sampled at a clock edge) |
| done_ack | input | 1 | Acknowledge and release done |
| pad_in | input | NUM_PINS | Pad levels seen by the tree |
| pin_drive | output | NUM_PINS | Levels the sequencer drives onto the pads |
| tree_out | output | 1 | Observation output of the tree |
| pin_fault | output | NUM_PINS | One fault flag per pad |
| done | output | 1 | Walk finished, result valid |
| pass | output | 1 | Walk finished with no fault |

## Verification
A wrong step counter is visible on pin_drive one clock after the bad edge, as a pattern that is not a low prefix or a step that lasts the wrong length. A wrong settle counter moves the rise of done away from (NUM_PINS+1)*(settle_cycles+2) edges. A corrupted reference level or fault latch does not reach the ports until done, where it appears as a wrong pin_fault pattern or a wrong pass. Stuck-high and stuck-low pads at every index are walked with several settle values, so that each comparison lands on a known toggle or non-toggle.

// File: rtl/nt_pkg.sv
// Shared types for the NAND tree connectivity tester.
// Assumes: nothing beyond a synthesizable enum.
package nt_pkg;
    // Walk sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/nt_tree.sv
// NAND chain over the pads. Stage 0 inverts pad 0, and each later stage
// NANDs its pad with the previous stage. A final inversion is added for an
// even pad count, so that all-high pads give a low output.
// Assumes: NUM_PINS >= 2; the output is combinational and gated by enable.
module nt_tree #(
    parameter int NUM_PINS = 8
) (
    input  logic                enable,
    input  logic [NUM_PINS-1:0] pad,
    output logic                obs
);
    localparam logic FLIP_OUT = ((NUM_PINS % 2) == 0);

    logic [NUM_PINS-1:0] stage;

    // Build the chain one stage per pad
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage[i] = ~pad[i];
        end else begin : g_rest
            assign stage[i] = ~(pad[i] & stage[i-1]);
        end
    end

    // Gate and polarity-correct the chain output
    assign obs = enable & (stage[NUM_PINS-1] ^ FLIP_OUT);
endmodule

// File: rtl/nt_sequencer.sv
// Walk sequencer. On an accepted start it holds all pads high, then lowers
// them one per step in index order. It samples the registered observation
// level at the end of each step and flags a pad whose step produced no
// toggle.
// Assumes: obs_raw settles within one clock of a pin_drive change when
// settle_cycles is 0; start and done_ack are synchronous to clk.
module nt_sequencer
    import nt_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                test_en,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                start,
    input  logic                done_ack,
    input  logic                obs_raw,
    output logic [NUM_PINS-1:0] pin_drive,
    output logic [NUM_PINS-1:0] fault,
    output logic                done,
    output logic                pass
);
    localparam int STEP_W = $clog2(NUM_PINS + 1);
    localparam int CNT_W  = SETTLE_W + 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_PINS);

    seq_state_t          state;
    logic [STEP_W-1:0]   step;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    reload;
    logic                obs_q;
    logic                prev_lvl;
    logic [NUM_PINS-1:0] fault_q;

    assign reload = CNT_W'(settle_cycles) + CNT_W'(1);

    // Register the observation output before it is compared
    always_ff @(posedge clk) begin
        if (!rst_n) obs_q <= 1'b0;
        else        obs_q <= obs_raw;
    end

    // Walk state machine, step counter, settle counter and fault capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            step     <= '0;
            cnt      <= '0;
            prev_lvl <= 1'b0;
            fault_q  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start && test_en) begin
                        state   <= SQ_WAIT;
                        step    <= '0;
                        cnt     <= reload;
                        fault_q <= '0;
                    end
                end
                SQ_WAIT: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else begin
                        prev_lvl <= obs_q;
                        for (int i = 0; i < NUM_PINS; i++) begin
                            if (step == STEP_W'(i + 1)) fault_q[i] <= (obs_q == prev_lvl);
                        end
                        if (step == LAST_STEP) begin
                            state <= SQ_DONE;
                        end else begin
                            step <= step + STEP_W'(1);
                            cnt  <= reload;
                        end
                    end
                end
                SQ_DONE: begin
                    if (done_ack) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Drive the low prefix for the current step; all high when idle
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            pin_drive[i] = (state == SQ_IDLE) || (STEP_W'(i) >= step);
        end
    end

    // Result outputs
    assign fault = fault_q;
    assign done  = (state == SQ_DONE);
    assign pass  = done && (fault_q == '0);
endmodule

// File: rtl/nand_tree_checker.sv
// Top of the NAND tree connectivity tester. It combines the tree enable
// sources and joins the NAND chain to the walk sequencer.
// Assumes: pad_in carries pin_drive back through the pads in test use;
// strap_en and cfg_test_en are static during a walk.
module nand_tree_checker #(
    parameter int NUM_PINS = 8,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_en,
    input  logic                cfg_test_en,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                start,
    input  logic                done_ack,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pin_drive,
    output logic                tree_out,
    output logic [NUM_PINS-1:0] pin_fault,
    output logic                done,
    output logic                pass
);
    logic test_en;

    // Either source activates the tree
    assign test_en = strap_en | cfg_test_en;

    nt_tree #(.NUM_PINS(NUM_PINS)) u_tree (
        .enable (test_en),
        .pad    (pad_in),
        .obs    (tree_out)
    );

    nt_sequencer #(.NUM_PINS(NUM_PINS), .SETTLE_W(SETTLE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .test_en       (test_en),
        .settle_cycles (settle_cycles),
        .start         (start),
        .done_ack      (done_ack),
        .obs_raw       (tree_out),
        .pin_drive     (pin_drive),
        .fault         (pin_fault),
        .done          (done),
        .pass          (pass)
    );
endmodule

// File: rtl/nand_tree_checker_chk.sv
// Property checker for nand_tree_checker, bound to every instance.
// Assumes: reset is held low from time zero.
module nand_tree_checker_chk #(
    parameter int NUM_PINS = 8,
    parameter int SETTLE_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                strap_en,
    input logic                cfg_test_en,
    input logic [SETTLE_W-1:0] settle_cycles,
    input logic                start,
    input logic                done_ack,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pin_drive,
    input logic                tree_out,
    input logic [NUM_PINS-1:0] pin_fault,
    input logic                done,
    input logic                pass
);
    logic [NUM_PINS-1:0] low_mask;
    logic                is_prefix;

    assign low_mask  = ~pad_in;
    assign is_prefix = ((low_mask & (low_mask + NUM_PINS'(1))) == '0);

    // R2: inactive tree keeps its output low
    p_inactive_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(strap_en || cfg_test_en) |-> !tree_out);

    // R3: a low prefix of k pads gives output parity of k
    p_prefix_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((strap_en || cfg_test_en) && is_prefix) |-> (tree_out == (^low_mask)));

    // R4: pads are lowered at most one per edge
    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones($past(pin_drive)) > $countones(pin_drive)) |->
        ($countones($past(pin_drive)) - $countones(pin_drive) == 1));

    // R7: pass only with a finished clean walk
    p_pass_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && (pin_fault == '0)));

    // R8: done holds until acknowledged
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ack) |=> done);

    // R9: acknowledge releases done and the pads, keeping the faults
    p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ack) |=> (!done && (pin_drive == '1) && $stable(pin_fault)));
endmodule

bind nand_tree_checker nand_tree_checker_chk #(
    .NUM_PINS (NUM_PINS),
    .SETTLE_W (SETTLE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_en      (strap_en),
    .cfg_test_en   (cfg_test_en),
    .settle_cycles (settle_cycles),
    .start         (start),
    .done_ack      (done_ack),
    .pad_in        (pad_in),
    .pin_drive     (pin_drive),
    .tree_out      (tree_out),
    .pin_fault     (pin_fault),
    .done          (done),
    .pass          (pass)
);

// File: tb/nand_tree_checker_bench.sv
// Bench: exhaustive tree sweep, then walks over every single stuck pad.
module nand_tree_checker_bench;
    localparam int NP = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_en = 1'b0;
    logic          cfg_test_en = 1'b0;
    logic [SW-1:0] settle_cycles = '0;
    logic          start = 1'b0;
    logic          done_ack = 1'b0;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pin_drive;
    logic          tree_out;
    logic [NP-1:0] pin_fault;
    logic          done;
    logic          pass;

    logic          direct_mode = 1'b1;
    logic [NP-1:0] direct_pad = '1;
    logic [NP-1:0] stuck_hi = '0;
    logic [NP-1:0] stuck_lo = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    assign pad_in = direct_mode ? direct_pad : ((pin_drive | stuck_hi) & ~stuck_lo);

    nand_tree_checker #(.NUM_PINS(NP), .SETTLE_W(SW)) u_nand_tree_checker (
        .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .cfg_test_en(cfg_test_en),
        .settle_cycles(settle_cycles), .start(start), .done_ack(done_ack),
        .pad_in(pad_in), .pin_drive(pin_drive), .tree_out(tree_out),
        .pin_fault(pin_fault), .done(done), .pass(pass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Expected tree level: 1 when the highest low pad index is even
    function automatic logic level_of(input logic [NP-1:0] p);
        level_of = 1'b0;
        for (int j = 0; j < NP; j++) if (!p[j]) level_of = ((j % 2) == 0);
    endfunction

    function automatic logic [NP-1:0] prefix(input int k);
        prefix = '1;
        for (int j = 0; j < NP; j++) if (j < k) prefix[j] = 1'b0;
    endfunction

    task automatic run_walk(input int st, input logic [NP-1:0] sh,
                            input logic [NP-1:0] sl, input bit use_strap);
        int c;
        int seq_err;
        int t_step;
        logic [NP-1:0] exp_fault;
        logic lprev;
        logic lcur;
        logic [NP-1:0] held;
        t_step = st + 2;
        lprev = level_of((prefix(0) | sh) & ~sl);
        for (int k = 1; k <= NP; k++) begin
            lcur = level_of((prefix(k) | sh) & ~sl);
            exp_fault[k-1] = (lcur == lprev);
            lprev = lcur;
        end
        @(negedge clk);
        direct_mode = 1'b0;
        stuck_hi = sh;
        stuck_lo = sl;
        settle_cycles = SW'(st);
        strap_en = use_strap;
        cfg_test_en = !use_strap;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        c = 0;
        seq_err = 0;
        while (!done && c < 2000) begin
            if (pin_drive != prefix((c / t_step) > NP ? NP : (c / t_step))) seq_err++;
            @(posedge clk);
            c++;
            @(negedge clk);
        end
        chk(seq_err == 0, "R4 walk order", seq_err, 0);
        chk(c == (NP + 1) * t_step, "R5 walk length", c, (NP + 1) * t_step);
        chk(pin_fault == exp_fault, "R6 fault vector", int'(pin_fault), int'(exp_fault));
        chk(pass == (exp_fault == '0), "R7 pass", int'(pass), int'(exp_fault == '0));
        held = pin_fault;
        // R8: start while done is ignored
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(done && pin_fault == held && pin_drive == '0, "R8 start during done",
            int'(done), 1);
        // R9: acknowledge
        done_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        done_ack = 1'b0;
        chk(!done && !pass && pin_drive == '1 && pin_fault == held, "R9 ack release",
            int'(pin_drive), int'(prefix(0)));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !pass && pin_fault == '0 && pin_drive == '1, "R1 reset",
            int'(pin_drive), int'(prefix(0)));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !pass && pin_fault == '0 && pin_drive == '1, "R1 after reset",
            int'(pin_drive), int'(prefix(0)));

        // R2 and R3: exhaustive tree sweep under every enable combination
        for (int en = 0; en < 4; en++) begin
            for (int p = 0; p < (1 << NP); p++) begin
                strap_en = en[0];
                cfg_test_en = en[1];
                direct_pad = NP'(p);
                #2;
                if (en == 0)
                    chk(tree_out == 1'b0, "R2 inactive tree", int'(tree_out), 0);
                else
                    chk(tree_out == level_of(NP'(p)), "R3 tree level", int'(tree_out),
                        int'(level_of(NP'(p))));
                @(negedge clk);
            end
        end

        // R8: start ignored while the tree is inactive
        strap_en = 1'b0;
        cfg_test_en = 1'b0;
        settle_cycles = '0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk(!done && pin_drive == '1 && pin_fault == '0, "R8 start while inactive",
            int'(done), 0);

        // R4..R9: clean walks and every single stuck pad, several settle values
        for (int s = 0; s < 4; s++) begin
            int st;
            st = (s == 3) ? 7 : s;
            run_walk(st, '0, '0, s[0]);
            for (int i = 0; i < NP; i++) begin
                run_walk(st, NP'(1) << i, '0, s[0]);
                run_walk(st, '0, NP'(1) << i, !s[0]);
            end
        end
        // R6: new walk clears faults from an earlier failing walk
        run_walk(0, NP'(1), '0, 1'b1);
        run_walk(1, '0, '0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule